// File: doc/BRIEF.md
# Index Register Address Generator

This block forms operand addresses for a controller-style processor. It keeps sixteen 32-bit pointer registers and sixteen 32-bit offset registers. Each operand request names one pointer register and an addressing mode. The block returns the resulting memory address one clock later, with a single-cycle valid pulse. Some modes also update the named pointer on that same clock edge, so a pointer can walk through a table.

The available modes are: use the pointer as it is; add a signed 12-bit immediate; add the signed low half of an offset register; use the pointer and then advance it by one or two; or retreat the pointer by one or two and then use it. A separate load mode writes a supplied address into a pointer. The offset registers are filled through their own write port.

An error input tells the block that the current instruction has faulted. By default this input changes nothing: pointer updates still commit and the address is still produced. Decoding instructions, the memory itself and operand width are handled elsewhere.

Top module: `ixag_top`

## Requirements
- R1: A synchronous active-high `rst` clears all pointer and offset registers to zero and drives `ea_out` to zero and `ea_vld` low.
- R2: Mode code 5 (load) writes `load_addr` into pointer `req_ir` and produces no valid pulse.
- R3: Mode code 0 (indirect) returns the pointer contents unchanged as the address and leaves the pointer unchanged.
- R4: Mode code 1 (immediate offset) returns the pointer plus `imm_off` read as a signed 12-bit value (-2048 to +2047), and leaves the pointer unchanged.
- R5: Mode code 2 (register offset) returns the pointer plus bits 15:0 of offset register `req_dr` read as a signed value. Bits 31:16 of that register are ignored, and the pointer is unchanged.
- R6: Mode code 3 (post-increment) returns the old pointer value, then advances the pointer by 2 when `req_step2` is 1 and by 1 when it is 0.
- R7: Mode code 4 (pre-decrement) lowers the pointer by 2 when `req_step2` is 1 and by 1 when it is 0, and returns the lowered value.
- R8: `err_in` has no effect: both the address and the pointer updates are the same with it high as with it low.
- R9: A request seen at a rising edge with `req_vld` high gives `ea_out` and a one-cycle `ea_vld` pulse after that edge. Without a request, `ea_vld` is low and `ea_out` holds its value.
- R10: All address arithmetic wraps modulo 2^32.
- R11: With `dr_we` high, `dr_wdata` is written into offset register `dr_waddr`. A request in the same cycle still sees the old contents.
- R12: Mode codes 6 and 7 produce no valid pulse and change no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request strobe |
| req_mode | input | 3 | Addressing mode code |
| req_ir | input | 4 | Pointer register select |
| req_dr | input | 4 | Offset register select for register-offset mode |
| req_step2 | input | 1 | Step of 2 (1) or 1 (0) for the increment and decrement modes |
| imm_off | input | 12 | Signed immediate offset |
| load_addr | input | 32 | Address written by load mode |
| err_in | input | 1 | Instruction error indication |
| dr_we | input | 1 | Offset register write enable |
| dr_waddr | input | 4 | Offset register write select |
| dr_wdata | input | 32 | Offset register write data |
| ea_out | output | 32 | Effective address |
| ea_vld | output | 1 | One-cycle valid pulse for `ea_out` |

## Verification
A corrupted pointer stays hidden until that pointer is next used. It then shows on `ea_out` exactly one clock after the request that names it. Because of this, every pointer update is followed directly by an indirect read of the same pointer. That read exposes a wrong step, a wrong direction, or a write-back that went to the wrong register or was dropped on error.

A stuck or doubled `ea_vld` appears within a single idle cycle. Offset register faults show through the register-offset sum, including the same-cycle write case.

// File: rtl/ixag_pkg.sv
package ixag_pkg;

    parameter int unsigned ADDR_W = 32;
    parameter int unsigned IR_N   = 16;
    parameter int unsigned DR_N   = 16;
    parameter int unsigned COFF_W = 12;
    parameter int unsigned DOFF_W = 16;
    parameter int unsigned MODE_W = 3;

    localparam int unsigned IR_SEL_W = $clog2(IR_N);
    localparam int unsigned DR_SEL_W = $clog2(DR_N);

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [MODE_W-1:0] {
        AM_IND  = 3'd0,
        AM_COFF = 3'd1,
        AM_DOFF = 3'd2,
        AM_PINC = 3'd3,
        AM_PDEC = 3'd4,
        AM_LOAD = 3'd5
    } amode_e;

    typedef struct packed {
        addr_t ea;
        addr_t ir_nxt;
        logic  ir_we;
        logic  fire;
    } calc_res_t;

    function automatic addr_t sext_coff(input logic [COFF_W-1:0] v);
        return {{(ADDR_W-COFF_W){v[COFF_W-1]}}, v};
    endfunction

    function automatic addr_t sext_doff(input logic [DOFF_W-1:0] v);
        return {{(ADDR_W-DOFF_W){v[DOFF_W-1]}}, v};
    endfunction

    function automatic addr_t step_amt(input logic two);
        return two ? addr_t'(2) : addr_t'(1);
    endfunction

    function automatic logic is_operand(input logic [MODE_W-1:0] m);
        return (m <= MODE_W'(AM_PDEC));
    endfunction

endpackage

// File: rtl/ixag_regfile.sv
module ixag_regfile #(
    parameter int unsigned N     = 16,
    parameter int unsigned W     = 32,
    parameter int unsigned RD_W  = 32,
    localparam int unsigned SEL_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] wsel,
    input  logic [W-1:0]     wdata,
    input  logic [SEL_W-1:0] rsel,
    output logic [RD_W-1:0]  rdata
);
    logic [W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (we && (wsel == SEL_W'(g)))
                regs[g] <= wdata;
        end
    end

    assign rdata = regs[rsel][RD_W-1:0];

endmodule

// File: rtl/ixag_ea_calc.sv
module ixag_ea_calc
    import ixag_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  addr_t             ir_val,
    input  logic [DOFF_W-1:0] dr_low,
    input  logic [COFF_W-1:0] coff,
    input  logic              step2,
    input  addr_t             load_addr,
    output calc_res_t         res
);
    addr_t step;

    always_comb begin
        step       = step_amt(step2);
        res        = '0;
        res.ea     = ir_val;
        res.ir_nxt = ir_val;
        case (mode)
            AM_IND: begin
                res.fire = 1'b1;
            end
            AM_COFF: begin
                res.ea   = ir_val + sext_coff(coff);
                res.fire = 1'b1;
            end
            AM_DOFF: begin
                res.ea   = ir_val + sext_doff(dr_low);
                res.fire = 1'b1;
            end
            AM_PINC: begin
                res.ir_nxt = ir_val + step;
                res.ir_we  = 1'b1;
                res.fire   = 1'b1;
            end
            AM_PDEC: begin
                res.ir_nxt = ir_val - step;
                res.ea     = ir_val - step;
                res.ir_we  = 1'b1;
                res.fire   = 1'b1;
            end
            AM_LOAD: begin
                res.ir_nxt = load_addr;
                res.ir_we  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ixag_out_stage.sv
module ixag_out_stage
    import ixag_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    input  addr_t ea_in,
    output addr_t ea_q,
    output logic  vld_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ea_q  <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= take;
            if (take)
                ea_q <= ea_in;
        end
    end

endmodule

// File: rtl/ixag_top.sv
module ixag_top
    import ixag_pkg::*;
#(
    parameter bit ERR_BLOCKS_WB = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_vld,
    input  logic [MODE_W-1:0]   req_mode,
    input  logic [IR_SEL_W-1:0] req_ir,
    input  logic [DR_SEL_W-1:0] req_dr,
    input  logic                req_step2,
    input  logic [COFF_W-1:0]   imm_off,
    input  logic [ADDR_W-1:0]   load_addr,
    input  logic                err_in,
    input  logic                dr_we,
    input  logic [DR_SEL_W-1:0] dr_waddr,
    input  logic [ADDR_W-1:0]   dr_wdata,
    output logic [ADDR_W-1:0]   ea_out,
    output logic                ea_vld
);
    addr_t             ir_rd;
    logic [DOFF_W-1:0] dr_rd;
    calc_res_t         calc;
    logic              wb_allow;
    logic              ir_wr;

    assign wb_allow = ~(err_in & ERR_BLOCKS_WB);
    assign ir_wr    = req_vld & calc.ir_we & wb_allow;

    ixag_regfile #(.N(IR_N), .W(ADDR_W), .RD_W(ADDR_W)) u_ir (
        .clk   (clk),
        .rst   (rst),
        .we    (ir_wr),
        .wsel  (req_ir),
        .wdata (calc.ir_nxt),
        .rsel  (req_ir),
        .rdata (ir_rd)
    );

    ixag_regfile #(.N(DR_N), .W(ADDR_W), .RD_W(DOFF_W)) u_dr (
        .clk   (clk),
        .rst   (rst),
        .we    (dr_we),
        .wsel  (dr_waddr),
        .wdata (dr_wdata),
        .rsel  (req_dr),
        .rdata (dr_rd)
    );

    ixag_ea_calc u_calc (
        .mode      (req_mode),
        .ir_val    (ir_rd),
        .dr_low    (dr_rd),
        .coff      (imm_off),
        .step2     (req_step2),
        .load_addr (load_addr),
        .res       (calc)
    );

    ixag_out_stage u_out (
        .clk   (clk),
        .rst   (rst),
        .take  (req_vld & calc.fire),
        .ea_in (calc.ea),
        .ea_q  (ea_out),
        .vld_q (ea_vld)
    );

endmodule

// File: rtl/ixag_chk.sv
module ixag_chk
    import ixag_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                req_vld,
    input logic [MODE_W-1:0]   req_mode,
    input logic [IR_SEL_W-1:0] req_ir,
    input logic                req_step2,
    input logic [COFF_W-1:0]   imm_off,
    input logic [ADDR_W-1:0]   ea_out,
    input logic                ea_vld
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!ea_vld && ea_out == '0)); // R1

    AST_VLD_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req_mode <= 3'd4) |=> ea_vld); // R9

    AST_NO_VLD_OTHER: assert property (@(posedge clk) disable iff (rst)
        !(req_vld && req_mode <= 3'd4) |=> !ea_vld); // R12

    AST_EA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !req_vld |=> $stable(ea_out)); // R9

    AST_COFF_SUM: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req_mode == 3'd1 && !$past(rst) && $past(req_vld)
         && $past(req_mode) == 3'd0 && $past(req_ir) == req_ir)
        |=> ea_out == $past(ea_out) + sext_coff($past(imm_off))); // R4

    AST_PINC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req_mode == 3'd0 && !$past(rst) && $past(req_vld)
         && $past(req_mode) == 3'd3 && $past(req_ir) == req_ir)
        |=> ea_out == $past(ea_out) + step_amt($past(req_step2, 2))); // R6

    AST_PDEC_RETREAT: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req_mode == 3'd4 && !$past(rst) && $past(req_vld)
         && $past(req_mode) == 3'd0 && $past(req_ir) == req_ir)
        |=> ea_out == $past(ea_out) - step_amt($past(req_step2))); // R7

endmodule

bind ixag_top ixag_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_vld   (req_vld),
    .req_mode  (req_mode),
    .req_ir    (req_ir),
    .req_step2 (req_step2),
    .imm_off   (imm_off),
    .ea_out    (ea_out),
    .ea_vld    (ea_vld)
);

// File: tb/sim_ixag_top.sv
`timescale 1ns/1ps
module sim_ixag_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_vld = 1'b0;
    logic [2:0]  req_mode = '0;
    logic [3:0]  req_ir = '0;
    logic [3:0]  req_dr = '0;
    logic        req_step2 = 1'b0;
    logic [11:0] imm_off = '0;
    logic [31:0] load_addr = '0;
    logic        err_in = 1'b0;
    logic        dr_we = 1'b0;
    logic [3:0]  dr_waddr = '0;
    logic [31:0] dr_wdata = '0;
    logic [31:0] ea_out;
    logic        ea_vld;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ixag_top u0 (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_mode(req_mode),
        .req_ir(req_ir), .req_dr(req_dr), .req_step2(req_step2),
        .imm_off(imm_off), .load_addr(load_addr), .err_in(err_in),
        .dr_we(dr_we), .dr_waddr(dr_waddr), .dr_wdata(dr_wdata),
        .ea_out(ea_out), .ea_vld(ea_vld)
    );

    typedef struct packed {
        logic [2:0]  mode;
        logic [3:0]  ir;
        logic [3:0]  dr;
        logic        s2;
        logic [11:0] off;
        logic [31:0] addr;
        logic        err;
        logic        vld;
        logic [31:0] ea;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{3'd5, 4'd0,  4'd0, 1'b0, 12'h000, 32'h0000_1000, 1'b0, 1'b0, 32'h0,          4'd2},  // R2 load
        '{3'd0, 4'd0,  4'd0, 1'b0, 12'h000, 32'h0,         1'b0, 1'b1, 32'h0000_1000, 4'd3},  // R3
        '{3'd1, 4'd0,  4'd0, 1'b0, 12'h005, 32'h0,         1'b0, 1'b1, 32'h0000_1005, 4'd4},  // R4
        '{3'd1, 4'd0,  4'd0, 1'b0, 12'h800, 32'h0,         1'b0, 1'b1, 32'h0000_0800, 4'd4},  // R4 -2048
        '{3'd1, 4'd0,  4'd0, 1'b0, 12'h7FF, 32'h0,         1'b0, 1'b1, 32'h0000_17FF, 4'd4},  // R4 +2047
        '{3'd0, 4'd0,  4'd0, 1'b0, 12'h000, 32'h0,         1'b0, 1'b1, 32'h0000_1000, 4'd4},  // R4 pointer kept
        '{3'd2, 4'd0,  4'd5, 1'b0, 12'h000, 32'h0,         1'b0, 1'b1, 32'h0000_1100, 4'd5},  // R5 +256
        '{3'd2, 4'd0,  4'd3, 1'b0, 12'h000, 32'h0,         1'b0, 1'b1, 32'h0000_0FF0, 4'd5},  // R5 -16
        '{3'd3, 4'd0,  4'd0, 1'b1, 12'h000, 32'h0,         1'b0, 1'b1, 32'h0000_1000, 4'd6},  // R6 by 2
        '{3'd3, 4'd0,  4'd0, 1'b0, 12'h000, 32'h0,         1'b0, 1'b1, 32'h0000_1002, 4'd6},  // R6 by 1
        '{3'd0, 4'd0,  4'd0, 1'b0, 12'h000, 32'h0,         1'b0, 1'b1, 32'h0000_1003, 4'd6},  // R6 result
        '{3'd4, 4'd0,  4'd0, 1'b1, 12'h000, 32'h0,         1'b0, 1'b1, 32'h0000_1001, 4'd7},  // R7 by 2
        '{3'd4, 4'd0,  4'd0, 1'b0, 12'h000, 32'h0,         1'b0, 1'b1, 32'h0000_1000, 4'd7},  // R7 by 1
        '{3'd5, 4'd15, 4'd0, 1'b0, 12'h000, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0,          4'd2},  // R2 load
        '{3'd3, 4'd15, 4'd0, 1'b1, 12'h000, 32'h0,         1'b1, 1'b1, 32'hFFFF_FFFF, 4'd8},  // R8 err
        '{3'd0, 4'd15, 4'd0, 1'b0, 12'h000, 32'h0,         1'b0, 1'b1, 32'h0000_0001, 4'd10}, // R10 wrap up
        '{3'd4, 4'd15, 4'd0, 1'b1, 12'h000, 32'h0,         1'b1, 1'b1, 32'hFFFF_FFFF, 4'd8},  // R8 err
        '{3'd5, 4'd7,  4'd0, 1'b0, 12'h000, 32'h0,         1'b0, 1'b0, 32'h0,          4'd2},  // R2 load
        '{3'd4, 4'd7,  4'd0, 1'b0, 12'h000, 32'h0,         1'b0, 1'b1, 32'hFFFF_FFFF, 4'd10}, // R10 wrap down
        '{3'd1, 4'd7,  4'd0, 1'b0, 12'h001, 32'h0,         1'b0, 1'b1, 32'h0000_0000, 4'd10}, // R10 sum wrap
        '{3'd6, 4'd0,  4'd0, 1'b1, 12'h000, 32'h0,         1'b0, 1'b0, 32'h0,          4'd12}, // R12
        '{3'd0, 4'd0,  4'd0, 1'b0, 12'h000, 32'h0,         1'b0, 1'b1, 32'h0000_1000, 4'd12}, // R12 pointer kept
        '{3'd0, 4'd1,  4'd0, 1'b0, 12'h000, 32'h0,         1'b0, 1'b1, 32'h0000_0000, 4'd1}   // R1 untouched
    };

    task automatic check_eq(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] m, input logic [3:0] ir, input logic [3:0] dr,
                         input logic s2, input logic [11:0] off, input logic [31:0] a,
                         input logic e);
        req_vld = 1'b1; req_mode = m; req_ir = ir; req_dr = dr;
        req_step2 = s2; imm_off = off; load_addr = a; err_in = e;
    endtask

    task automatic idle();
        req_vld = 1'b0; req_mode = '0; err_in = 1'b0;
    endtask

    task automatic wr_dr(input logic [3:0] a, input logic [31:0] d);
        dr_we = 1'b1; dr_waddr = a; dr_wdata = d;
        @(negedge clk);
        dr_we = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq("R1 ea after reset", ea_out, 32'h0);
        check_eq("R1 vld after reset", {31'b0, ea_vld}, 32'h0);
        rst = 1'b0;

        wr_dr(4'd3, 32'hABCD_FFF0);   // R5: upper half must be ignored
        wr_dr(4'd5, 32'h0000_0100);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].mode, VECS[i].ir, VECS[i].dr, VECS[i].s2,
                  VECS[i].off, VECS[i].addr, VECS[i].err);
            @(negedge clk);
            check_eq($sformatf("R%0d vld vec %0d", VECS[i].rq, i), {31'b0, ea_vld}, {31'b0, VECS[i].vld});
            if (VECS[i].vld)
                check_eq($sformatf("R%0d ea vec %0d", VECS[i].rq, i), ea_out, VECS[i].ea);
        end

        // R9: hold and single pulse
        idle();
        @(negedge clk);
        check_eq("R9 vld drops when idle", {31'b0, ea_vld}, 32'h0);
        check_eq("R9 ea held when idle", ea_out, 32'h0000_0000);
        @(negedge clk);
        check_eq("R9 ea still held", ea_out, 32'h0000_0000);

        // R11: same-cycle offset write sees the old value
        drive(3'd5, 4'd2, 4'd0, 1'b0, 12'h0, 32'h0000_2000, 1'b0);
        @(negedge clk);
        drive(3'd2, 4'd2, 4'd9, 1'b0, 12'h0, 32'h0, 1'b0);
        dr_we = 1'b1; dr_waddr = 4'd9; dr_wdata = 32'h0000_0010;
        @(negedge clk);
        dr_we = 1'b0;
        check_eq("R11 old offset used", ea_out, 32'h0000_2000);
        @(negedge clk);
        check_eq("R11 new offset used", ea_out, 32'h0000_2010);

        // R1: reset in mid-run clears pointers and offsets
        idle();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_eq("R1 ea cleared mid-run", ea_out, 32'h0);
        drive(3'd0, 4'd2, 4'd0, 1'b0, 12'h0, 32'h0, 1'b0);
        @(negedge clk);
        check_eq("R1 pointer cleared", ea_out, 32'h0);
        drive(3'd2, 4'd0, 4'd9, 1'b0, 12'h0, 32'h0, 1'b0);
        @(negedge clk);
        check_eq("R1 offset cleared", ea_out, 32'h0);
        idle();
        @(negedge clk);

        summary();
        $finish;
    end

endmodule